// File: doc/BRIEF.md
# Micro-Op Affine Index Sequencer

This block expands one coarse compute instruction into a stream of operand index tuples. The instruction names a run of entries in a small micro-op store and gives two loop counts, an outer row count and an inner column count. For every (row, column) pair the sequencer walks the named micro-op run in order. For each micro-op it emits one tuple: a destination index, a source index and a weight index.

Each index in a tuple is an affine function of the loop position. The instruction supplies a row stride and a column stride for each of the three operand roles. The current micro-op supplies the constant offset for each role. Arithmetic wraps at the index width. A downstream execution unit consumes the tuples over a valid/ready stream. A one-cycle `done` pulse marks the end of each instruction.

The micro-op store has its own write port and is loaded before an instruction is issued. The parameter `USE_MUL` chooses how the strided terms are formed. One variant uses running sums and the other uses direct multipliers. Both variants give the same outputs.

Top module: `uop_affine_seq`

## Requirements
- R1: After reset the block is idle: `cmd_ready` is 1, and `out_valid` and `done` are 0.
- R2: Each emitted index for role r (destination, source, weight) equals (ystride_r·y + xstride_r·x + offset_r[u]) mod 2^IDX_W. Here y is the row number, x is the column number and u is the current micro-op entry.
- R3: Tuples come out in nested order. The micro-op entry u runs from `cmd_uop_begin` up to `cmd_uop_end`−1 innermost, then x runs from 0 to `cmd_cols`−1, then y runs from 0 to `cmd_rows`−1 outermost. An end value above UOP_DEPTH acts as UOP_DEPTH.
- R4: An instruction is empty when `cmd_rows` is 0, `cmd_cols` is 0, or the begin entry is not below the effective end. An empty instruction emits no tuple. `done` is then 1 in the cycle after acceptance, and the block stays idle.
- R5: `out_last` is 1 exactly on the final tuple of an instruction. `done` is 1 for exactly one cycle, the cycle after that tuple is accepted, and `out_valid` is then 0.
- R6: While `out_valid` is 1 and `out_ready` is 0, the presented tuple and the loop position hold unchanged.
- R7: While a non-empty instruction is streaming, `cmd_ready` is 0. Instruction inputs presented then are ignored and do not alter the tuples.
- R8: A write with `uop_we` high stores the three offsets at `uop_waddr` at the clock edge. Instructions issued later use the stored values, including values rewritten after an earlier use.
- R9: The running-sum variant (`USE_MUL`=0) and the multiplier variant (`USE_MUL`=1) produce identical tuple streams for identical stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Instruction offered |
| cmd_ready | output | 1 | Instruction accepted when high with cmd_valid |
| cmd_rows | input | LOOP_W | Outer loop count |
| cmd_cols | input | LOOP_W | Inner loop count |
| cmd_uop_begin | input | UAW | First micro-op entry |
| cmd_uop_end | input | UAW+1 | One past the last micro-op entry |
| cmd_dst_ystride | input | IDX_W | Destination row stride |
| cmd_dst_xstride | input | IDX_W | Destination column stride |
| cmd_src_ystride | input | IDX_W | Source row stride |
| cmd_src_xstride | input | IDX_W | Source column stride |
| cmd_wgt_ystride | input | IDX_W | Weight row stride |
| cmd_wgt_xstride | input | IDX_W | Weight column stride |
| uop_we | input | 1 | Micro-op store write enable |
| uop_waddr | input | UAW | Micro-op store write entry |
| uop_wdst | input | IDX_W | Destination offset to store |
| uop_wsrc | input | IDX_W | Source offset to store |
| uop_wwgt | input | IDX_W | Weight offset to store |
| out_valid | output | 1 | Tuple presented |
| out_ready | input | 1 | Consumer takes the tuple |
| out_dst | output | IDX_W | Destination index |
| out_src | output | IDX_W | Source index |
| out_wgt | output | IDX_W | Weight index |
| out_last | output | 1 | Final tuple of the instruction |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds two copies with UOP_DEPTH=8, IDX_W=6 and LOOP_W=3. One copy uses the running-sum variant and the other uses the multiplier variant, and both are checked against the same arithmetic model. The six-bit index width makes modular wrap-around frequent with ordinary strides. The three-bit loop counts let the sweep cover every row and column count from 0 to 3, plus the full count of 7. The eight-entry store makes single-entry runs, empty runs and end values clipped at the depth all cheap to reach.

// File: rtl/uas_pkg.sv
package uas_pkg;
   localparam int NUM_ROLES = 3;

   typedef enum logic [1:0] {
      ROLE_DST = 2'd0,
      ROLE_SRC = 2'd1,
      ROLE_WGT = 2'd2
   } role_e;
endpackage

// File: rtl/uas_uop_mem.sv
module uas_uop_mem #(
   parameter int DEPTH = 64,
   parameter int AW    = 6,
   parameter int IDX_W = 11
) (
   input  logic                                         clk,
   input  logic                                         we,
   input  logic [AW-1:0]                                waddr,
   input  logic [uas_pkg::NUM_ROLES-1:0][IDX_W-1:0]     wdata,
   input  logic [AW-1:0]                                raddr,
   output logic [uas_pkg::NUM_ROLES-1:0][IDX_W-1:0]     rdata
);
   localparam int SPAN = 1 << AW;

   if (SPAN < DEPTH) begin : g_bad_aw
      $error("uas_uop_mem: AW too narrow for DEPTH");
   end

   logic [uas_pkg::NUM_ROLES-1:0][IDX_W-1:0] store_q [SPAN];

   always_ff @(posedge clk) begin
      if (we && ({1'b0, waddr} < (AW+1)'(DEPTH))) begin
         store_q[waddr] <= wdata;
      end
   end

   assign rdata = store_q[raddr];
endmodule

// File: rtl/uas_loop_walker.sv
module uas_loop_walker #(
   parameter int DEPTH  = 64,
   parameter int AW     = 6,
   parameter int LOOP_W = 14
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [LOOP_W-1:0] cmd_rows,
   input  logic [LOOP_W-1:0] cmd_cols,
   input  logic [AW-1:0]     cmd_begin,
   input  logic [AW:0]       cmd_end,
   input  logic              out_ready,
   output logic              busy,
   output logic [LOOP_W-1:0] pos_y,
   output logic [LOOP_W-1:0] pos_x,
   output logic [AW-1:0]     uptr,
   output logic              start,
   output logic              col_adv,
   output logic              row_adv,
   output logic              last,
   output logic              done
);
   logic              busy_q, done_q;
   logic [LOOP_W-1:0] y_q, x_q, rows_q, cols_q;
   logic [AW-1:0]     u_q, ubeg_q;
   logic [AW:0]       uend_q, end_clip;
   logic              accept, empty, fire, u_last, x_last, y_last;

   assign end_clip  = (cmd_end > (AW+1)'(DEPTH)) ? (AW+1)'(DEPTH) : cmd_end;
   assign accept    = cmd_valid & ~busy_q;
   assign empty     = (cmd_rows == '0) | (cmd_cols == '0) | ({1'b0, cmd_begin} >= end_clip);
   assign fire      = busy_q & out_ready;
   assign u_last    = (({1'b0, u_q} + (AW+1)'(1)) == uend_q);
   assign x_last    = (x_q == cols_q - LOOP_W'(1));
   assign y_last    = (y_q == rows_q - LOOP_W'(1));

   assign cmd_ready = ~busy_q;
   assign busy      = busy_q;
   assign pos_y     = y_q;
   assign pos_x     = x_q;
   assign uptr      = u_q;
   assign start     = accept & ~empty;
   assign col_adv   = fire & u_last & ~x_last;
   assign row_adv   = fire & u_last & x_last & ~y_last;
   assign last      = busy_q & u_last & x_last & y_last;
   assign done      = done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         y_q    <= '0;
         x_q    <= '0;
         u_q    <= '0;
         rows_q <= '0;
         cols_q <= '0;
         ubeg_q <= '0;
         uend_q <= '0;
      end else begin
         done_q <= (accept & empty) | (fire & last);
         if (start) begin
            busy_q <= 1'b1;
            y_q    <= '0;
            x_q    <= '0;
            u_q    <= cmd_begin;
            rows_q <= cmd_rows;
            cols_q <= cmd_cols;
            ubeg_q <= cmd_begin;
            uend_q <= end_clip;
         end else if (fire) begin
            if (!u_last) begin
               u_q <= u_q + AW'(1);
            end else begin
               u_q <= ubeg_q;
               if (!x_last) begin
                  x_q <= x_q + LOOP_W'(1);
               end else begin
                  x_q <= '0;
                  if (!y_last) begin
                     y_q <= y_q + LOOP_W'(1);
                  end else begin
                     busy_q <= 1'b0;
                  end
               end
            end
         end
      end
   end

   // R6: a stalled tuple keeps its loop position
   assert_hold_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !out_ready) |=> ($stable(y_q) && $stable(x_q) && $stable(u_q) && busy_q));

   // R3: the entry pointer stays inside the instruction's run
   assert_uptr_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (({1'b0, u_q} < uend_q) && (u_q >= ubeg_q)));

   // R5: completion is reported only once streaming has stopped
   assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !busy_q);

   // R4: an empty instruction never starts streaming
   assert_empty_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && empty) |=> (!busy_q && done_q));
endmodule

// File: rtl/uas_affine_term.sv
module uas_affine_term #(
   parameter int IDX_W   = 11,
   parameter int LOOP_W  = 14,
   parameter bit USE_MUL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              active,
   input  logic              col_adv,
   input  logic              row_adv,
   input  logic [IDX_W-1:0]  ystride,
   input  logic [IDX_W-1:0]  xstride,
   input  logic [LOOP_W-1:0] pos_y,
   input  logic [LOOP_W-1:0] pos_x,
   input  logic [IDX_W-1:0]  offset,
   output logic [IDX_W-1:0]  index
);
   localparam int PW = IDX_W + LOOP_W;

   logic [IDX_W-1:0] ys_q, xs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ys_q <= '0;
         xs_q <= '0;
      end else if (start) begin
         ys_q <= ystride;
         xs_q <= xstride;
      end
   end

   if (USE_MUL) begin : g_mul
      logic [PW-1:0] prod_y, prod_x;
      assign prod_y = {{LOOP_W{1'b0}}, ys_q} * {{IDX_W{1'b0}}, pos_y};
      assign prod_x = {{LOOP_W{1'b0}}, xs_q} * {{IDX_W{1'b0}}, pos_x};
      assign index  = prod_y[IDX_W-1:0] + prod_x[IDX_W-1:0] + offset;
   end else begin : g_sum
      logic [IDX_W-1:0] sum_y_q, sum_x_q;
      logic [PW-1:0]    ref_y, ref_x;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sum_y_q <= '0;
            sum_x_q <= '0;
         end else if (start) begin
            sum_y_q <= '0;
            sum_x_q <= '0;
         end else if (row_adv) begin
            sum_y_q <= sum_y_q + ys_q;
            sum_x_q <= '0;
         end else if (col_adv) begin
            sum_x_q <= sum_x_q + xs_q;
         end
      end

      assign index = sum_y_q + sum_x_q + offset;

      assign ref_y = {{LOOP_W{1'b0}}, ys_q} * {{IDX_W{1'b0}}, pos_y};
      assign ref_x = {{LOOP_W{1'b0}}, xs_q} * {{IDX_W{1'b0}}, pos_x};

      // R2: running sums agree with the product form at every position
      assert_rowsum_R2: assert property (@(posedge clk) disable iff (!rst_n)
         active |-> (sum_y_q == ref_y[IDX_W-1:0]));
      assert_colsum_R2: assert property (@(posedge clk) disable iff (!rst_n)
         active |-> (sum_x_q == ref_x[IDX_W-1:0]));
   end
endmodule

// File: rtl/uop_affine_seq.sv
module uop_affine_seq #(
   parameter int UOP_DEPTH = 64,
   parameter int IDX_W     = 11,
   parameter int LOOP_W    = 14,
   parameter bit USE_MUL   = 1'b0,
   parameter int UAW       = (UOP_DEPTH > 1) ? $clog2(UOP_DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [LOOP_W-1:0] cmd_rows,
   input  logic [LOOP_W-1:0] cmd_cols,
   input  logic [UAW-1:0]    cmd_uop_begin,
   input  logic [UAW:0]      cmd_uop_end,
   input  logic [IDX_W-1:0]  cmd_dst_ystride,
   input  logic [IDX_W-1:0]  cmd_dst_xstride,
   input  logic [IDX_W-1:0]  cmd_src_ystride,
   input  logic [IDX_W-1:0]  cmd_src_xstride,
   input  logic [IDX_W-1:0]  cmd_wgt_ystride,
   input  logic [IDX_W-1:0]  cmd_wgt_xstride,
   input  logic              uop_we,
   input  logic [UAW-1:0]    uop_waddr,
   input  logic [IDX_W-1:0]  uop_wdst,
   input  logic [IDX_W-1:0]  uop_wsrc,
   input  logic [IDX_W-1:0]  uop_wwgt,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [IDX_W-1:0]  out_dst,
   output logic [IDX_W-1:0]  out_src,
   output logic [IDX_W-1:0]  out_wgt,
   output logic              out_last,
   output logic              done
);
   import uas_pkg::*;

   if (UOP_DEPTH < 2)           begin : g_bad_depth $error("UOP_DEPTH must be at least 2"); end
   if (IDX_W < 2)               begin : g_bad_idx   $error("IDX_W must be at least 2"); end
   if (LOOP_W < 1)              begin : g_bad_loop  $error("LOOP_W must be at least 1"); end
   if ((1 << UAW) < UOP_DEPTH)  begin : g_bad_uaw   $error("UAW too narrow for UOP_DEPTH"); end

   logic [NUM_ROLES-1:0][IDX_W-1:0] wr_off, rd_off, ystr, xstr, idx;
   logic [LOOP_W-1:0] pos_y, pos_x;
   logic [UAW-1:0]    uptr;
   logic              busy, start, col_adv, row_adv, last;

   assign wr_off[ROLE_DST] = uop_wdst;
   assign wr_off[ROLE_SRC] = uop_wsrc;
   assign wr_off[ROLE_WGT] = uop_wwgt;
   assign ystr[ROLE_DST]   = cmd_dst_ystride;
   assign ystr[ROLE_SRC]   = cmd_src_ystride;
   assign ystr[ROLE_WGT]   = cmd_wgt_ystride;
   assign xstr[ROLE_DST]   = cmd_dst_xstride;
   assign xstr[ROLE_SRC]   = cmd_src_xstride;
   assign xstr[ROLE_WGT]   = cmd_wgt_xstride;

   uas_uop_mem #(.DEPTH(UOP_DEPTH), .AW(UAW), .IDX_W(IDX_W)) u_store (
      .clk   (clk),
      .we    (uop_we),
      .waddr (uop_waddr),
      .wdata (wr_off),
      .raddr (uptr),
      .rdata (rd_off)
   );

   uas_loop_walker #(.DEPTH(UOP_DEPTH), .AW(UAW), .LOOP_W(LOOP_W)) u_walk (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_ready (cmd_ready),
      .cmd_rows  (cmd_rows),
      .cmd_cols  (cmd_cols),
      .cmd_begin (cmd_uop_begin),
      .cmd_end   (cmd_uop_end),
      .out_ready (out_ready),
      .busy      (busy),
      .pos_y     (pos_y),
      .pos_x     (pos_x),
      .uptr      (uptr),
      .start     (start),
      .col_adv   (col_adv),
      .row_adv   (row_adv),
      .last      (last),
      .done      (done)
   );

   for (genvar r = 0; r < NUM_ROLES; r++) begin : g_role
      uas_affine_term #(.IDX_W(IDX_W), .LOOP_W(LOOP_W), .USE_MUL(USE_MUL)) u_term (
         .clk     (clk),
         .rst_n   (rst_n),
         .start   (start),
         .active  (busy),
         .col_adv (col_adv),
         .row_adv (row_adv),
         .ystride (ystr[r]),
         .xstride (xstr[r]),
         .pos_y   (pos_y),
         .pos_x   (pos_x),
         .offset  (rd_off[r]),
         .index   (idx[r])
      );
   end

   assign out_valid = busy;
   assign out_last  = last;
   assign out_dst   = idx[ROLE_DST];
   assign out_src   = idx[ROLE_SRC];
   assign out_wgt   = idx[ROLE_WGT];

   // R6: a refused tuple is presented again unchanged
   assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready && !uop_we) |=>
         (out_valid && $stable(out_dst) && $stable(out_src) && $stable(out_wgt) && $stable(out_last)));

   // R5: accepting the final tuple yields the done pulse next cycle
   assert_last_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> (done && !out_valid));

   // R7: no instruction is taken while streaming
   assert_busy_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !(out_ready && out_last)) |=> out_valid);
endmodule

// File: tb/test_uop_affine_seq.sv
`timescale 1ns/1ps
module test_uop_affine_seq;
   localparam int DEPTH = 8;
   localparam int IW    = 6;
   localparam int LW    = 3;
   localparam int AW    = 3;
   localparam int MASK  = (1 << IW) - 1;

   logic clk = 1'b0;
   logic rst_n;
   logic cmd_valid, out_ready, uop_we;
   logic [LW-1:0] cmd_rows, cmd_cols;
   logic [AW-1:0] cmd_begin, uop_waddr;
   logic [AW:0]   cmd_end;
   logic [IW-1:0] dys, dxs, sys, sxs, wys, wxs, wd, ws, ww;
   logic          rdy0, rdy1, ov0, ov1, ol0, ol1, dn0, dn1;
   logic [IW-1:0] od0, os0, ow0, od1, os1, ow1;

   int vectors = 0;
   int fails   = 0;
   int cyc     = 0;
   int cmem [3][DEPTH];
   int ca [3];
   int cb [3];

   always #4 clk = ~clk;

   uop_affine_seq #(.UOP_DEPTH(DEPTH), .IDX_W(IW), .LOOP_W(LW), .USE_MUL(1'b0)) i_uop_affine_seq (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy0),
      .cmd_rows(cmd_rows), .cmd_cols(cmd_cols), .cmd_uop_begin(cmd_begin), .cmd_uop_end(cmd_end),
      .cmd_dst_ystride(dys), .cmd_dst_xstride(dxs), .cmd_src_ystride(sys), .cmd_src_xstride(sxs),
      .cmd_wgt_ystride(wys), .cmd_wgt_xstride(wxs),
      .uop_we(uop_we), .uop_waddr(uop_waddr), .uop_wdst(wd), .uop_wsrc(ws), .uop_wwgt(ww),
      .out_valid(ov0), .out_ready(out_ready), .out_dst(od0), .out_src(os0), .out_wgt(ow0),
      .out_last(ol0), .done(dn0));

   uop_affine_seq #(.UOP_DEPTH(DEPTH), .IDX_W(IW), .LOOP_W(LW), .USE_MUL(1'b1)) i_uop_affine_seq_mul (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(rdy1),
      .cmd_rows(cmd_rows), .cmd_cols(cmd_cols), .cmd_uop_begin(cmd_begin), .cmd_uop_end(cmd_end),
      .cmd_dst_ystride(dys), .cmd_dst_xstride(dxs), .cmd_src_ystride(sys), .cmd_src_xstride(sxs),
      .cmd_wgt_ystride(wys), .cmd_wgt_xstride(wxs),
      .uop_we(uop_we), .uop_waddr(uop_waddr), .uop_wdst(wd), .uop_wsrc(ws), .uop_wwgt(ww),
      .out_valid(ov1), .out_ready(out_ready), .out_dst(od1), .out_src(os1), .out_wgt(ow1),
      .out_last(ol1), .done(dn1));

   task automatic chk(input string req, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         fails++;
         $display("FAIL watchdog actual=%0d expected=0", cyc);
         summary();
         $finish;
      end
   end

   task automatic write_uop(input int k, input int d, input int s, input int w);
      @(negedge clk);
      uop_we = 1'b1;
      uop_waddr = AW'(k);
      wd = IW'(d); ws = IW'(s); ww = IW'(w);
      cmem[0][k] = d & MASK; cmem[1][k] = s & MASK; cmem[2][k] = w & MASK;
      @(negedge clk);
      uop_we = 1'b0;
   endtask

   task automatic run_cmd(input int rows, input int cols, input int ub, input int ue,
                          input int seed, input bit intrude);
      int eff_end, step;
      bit empty;
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_rows = LW'(rows); cmd_cols = LW'(cols);
      cmd_begin = AW'(ub); cmd_end = (AW+1)'(ue);
      dys = IW'(ca[0]); dxs = IW'(cb[0]);
      sys = IW'(ca[1]); sxs = IW'(cb[1]);
      wys = IW'(ca[2]); wxs = IW'(cb[2]);
      @(negedge clk);
      if (intrude) begin
         // R7: a different instruction held on the inputs while streaming
         cmd_rows = LW'(1); cmd_cols = LW'(1); cmd_begin = '0; cmd_end = (AW+1)'(1);
         dys = 6'd1; dxs = 6'd2; sys = 6'd3; sxs = 6'd4; wys = 6'd5; wxs = 6'd6;
      end else begin
         cmd_valid = 1'b0;
      end
      eff_end = (ue > DEPTH) ? DEPTH : ue;
      empty = (rows == 0) || (cols == 0) || (ub >= eff_end);
      if (empty) begin
         #1;
         chk("R4 done after empty", int'(dn0), 1);
         chk("R4 no tuple", int'(ov0), 0);
         chk("R4 stays idle", int'(rdy0), 1);
         chk("R9 done variant", int'(dn1), 1);
         return;
      end
      step = 0;
      for (int y = 0; y < rows; y++) begin
         for (int x = 0; x < cols; x++) begin
            for (int u = ub; u < eff_end; u++) begin
               bit take, fin;
               int e0, e1, e2;
               fin = (y == rows-1) && (x == cols-1) && (u == eff_end-1);
               e0 = (ca[0]*y + cb[0]*x + cmem[0][u]) & MASK;
               e1 = (ca[1]*y + cb[1]*x + cmem[1][u]) & MASK;
               e2 = (ca[2]*y + cb[2]*x + cmem[2][u]) & MASK;
               do begin
                  take = ((step*7 + seed) % 3) != 0;
                  if (step > 3) cmd_valid = 1'b0;
                  out_ready = take;
                  #1;
                  chk(take ? "R3 valid" : "R6 valid held", int'(ov0), 1);
                  chk("R7 busy refuses cmd", int'(rdy0), 0);
                  chk(take ? "R2 dst" : "R6 dst held", int'(od0), e0);
                  chk(take ? "R2 src" : "R6 src held", int'(os0), e1);
                  chk(take ? "R2 wgt" : "R6 wgt held", int'(ow0), e2);
                  chk("R5 last flag", int'(ol0), int'(fin));
                  chk("R9 dst variant", int'(od1), e0);
                  chk("R9 src variant", int'(os1), e1);
                  chk("R9 wgt variant", int'(ow1), e2);
                  @(negedge clk);
                  step++;
               end while (!take);
            end
         end
      end
      out_ready = 1'b0;
      cmd_valid = 1'b0;
      #1;
      chk("R5 done pulse", int'(dn0), 1);
      chk("R5 valid drops", int'(ov0), 0);
      chk("R9 done variant", int'(dn1), 1);
      @(negedge clk);
      chk("R5 done one cycle", int'(dn0), 0);
   endtask

   initial begin
      rst_n = 1'b0;
      cmd_valid = 1'b0; out_ready = 1'b0; uop_we = 1'b0;
      cmd_rows = '0; cmd_cols = '0; cmd_begin = '0; cmd_end = '0;
      dys = '0; dxs = '0; sys = '0; sxs = '0; wys = '0; wxs = '0;
      uop_waddr = '0; wd = '0; ws = '0; ww = '0;
      repeat (3) @(negedge clk);
      chk("R1 cmd_ready", int'(rdy0), 1);
      chk("R1 out_valid", int'(ov0), 0);
      chk("R1 done", int'(dn0), 0);
      chk("R1 variant valid", int'(ov1), 0);
      rst_n = 1'b1;

      for (int k = 0; k < DEPTH; k++) write_uop(k, k*13 + 5, k*29 + 40, k*7 + 61);

      // sweep loop counts and micro-op runs, strides chosen to wrap
      for (int rows = 0; rows < 4; rows++) begin
         for (int cols = 0; cols < 4; cols++) begin
            for (int g = 0; g < 5; g++) begin
               int ub, ue, run;
               run = rows*20 + cols*5 + g;
               case (g)
                  0: begin ub = 0; ue = 8;  end
                  1: begin ub = 2; ue = 5;  end
                  2: begin ub = 5; ue = 5;  end
                  3: begin ub = 7; ue = 8;  end
                  default: begin ub = 6; ue = 15; end
               endcase
               for (int r = 0; r < 3; r++) begin
                  ca[r] = (run*11 + r*17 + 3) & MASK;
                  cb[r] = (run*23 + r*5 + 50) & MASK;
               end
               run_cmd(rows, cols, ub, ue, run, 1'b0);
            end
         end
      end

      // R3: full loop counts, begin above end is empty (R4)
      ca = '{63, 1, 32}; cb = '{31, 62, 17};
      run_cmd(7, 7, 0, 2, 1, 1'b0);
      run_cmd(2, 2, 6, 3, 2, 1'b0);

      // R7: inputs changing while busy are ignored
      ca = '{9, 44, 21}; cb = '{58, 3, 40};
      run_cmd(2, 2, 1, 4, 0, 1'b1);

      // R8: rewritten entries take effect in the next instruction
      run_cmd(1, 2, 1, 3, 5, 1'b0);
      write_uop(1, 60, 0, 33);
      write_uop(2, 11, 63, 2);
      run_cmd(1, 2, 1, 3, 5, 1'b0);
      chk("R8 store rewritten", cmem[0][1], 60);

      summary();
      $finish;
   end
endmodule